// File: doc/BRIEF.md
# Zero-Substitution Rail Decoder with Violation Flag

This block sits on the receive side of a coaxial line interface, after clock and data recovery. It takes the recovered positive and negative rails one symbol per bit-valid strobe. In NRZ mode it removes the zero-substitution patterns of either the three-zero (B3ZS) or four-zero (HDB3) line code and produces plain NRZ data. Alongside the data it gives a flag that marks illegal line-code events. Each event is flagged on exactly one output bit, and that bit is the symbol that completed the event.

In rail mode the block does not decode. The two rails pass through unchanged, and the flag output carries the negative rail. Both modes use the same fixed delay of four strobes. That delay lets the decoder see a whole four-symbol substitution before the first symbol of it leaves, so it can clear symbols it has already accepted.

Top module: `rzd_decoder`

## Requirements
- R1: With `nrz_sel` low, `nrz_data` and `viol_flag` repeat `rail_p` and `rail_n` unchanged, including the case where both rails are high.
- R2: In both modes, the result for the symbol sampled at strobe k appears after the clock edge of strobe k+4 and holds until the next strobe. A cycle with `bit_en` low changes neither the outputs nor the decoder state.
- R3: In NRZ mode a mark is a symbol with exactly one rail high (`rail_p` alone is positive, `rail_n` alone is negative). A space is both rails low or both rails high. A mark whose polarity differs from the previous mark, or the first mark after reset, decodes to 1 with no flag. A space decodes to 0.
- R4: With `hdb3_sel` low (B3ZS), a mark has the same polarity as the previous mark and follows at least one space. If an odd number of alternating marks has come since the last same-polarity mark, the substitution is legal: that mark and the two results before it decode to 0, with no flag. With `hdb3_sel` high (HDB3) the same rule applies, except that it needs at least two spaces and clears the three results before the mark.
- R5: Two adjacent marks of the same polarity decode to 1,1, and the flag is raised on the second.
- R6: In HDB3 mode the sequence mark, space, mark of the same polarity decodes to 1,0,1, and the flag is raised on the third symbol.
- R7: A same-polarity mark in the position of a substitution (R4), but with an even count of alternating marks, decodes to 1 and is flagged.
- R8: The third consecutive space in B3ZS mode, or the fourth in HDB3 mode, decodes to 0 and is flagged. This happens once per run, however long the run is.
- R9: The count of alternating marks is cleared by every same-polarity mark, whether legal or not, and by reset.
- R10: While `rst_n` is low both outputs are low. Reset clears the delay line and the decoder state, so the first four results after release are 0 with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Strobe: high for one cycle per received symbol |
| rail_p | input | 1 | Positive rail of the recovered symbol |
| rail_n | input | 1 | Negative rail of the recovered symbol |
| hdb3_sel | input | 1 | Code select: 1 for HDB3, 0 for B3ZS |
| nrz_sel | input | 1 | Mode select: 1 decodes to NRZ, 0 passes the rails through |
| nrz_data | output | 1 | Decoded data, or the positive rail in rail mode |
| viol_flag | output | 1 | Violation flag, or the negative rail in rail mode |

## Verification
A wrong parity bit makes a legal substitution show up at the ports as a flagged 1, or makes a coding violation vanish. Either error appears on the output bit that is four strobes after the offending mark. A stuck or wrong zero-run count moves the excessive-zero flag, or the decision between a legal and an illegal pattern, by at least one bit. A fault in clearing the delay line leaves a stray 1 on one of the three or four bits before a substitution. Streams built by a reference encoder must therefore decode back to their source bits with no flag at all, and any deviation is visible within five strobes.

// File: rtl/rzd_pkg.sv
package rzd_pkg;

    // Classification of one incoming symbol in NRZ mode
    typedef enum logic [2:0] {
        SYM_SPACE,   // space, run still short
        SYM_EXZ,     // space completing an excessive-zero run
        SYM_MARK,    // alternating mark
        SYM_SUBST,   // same-polarity mark closing a legal substitution
        SYM_BPV,     // same-polarity mark too close to the previous mark
        SYM_CODEV    // substitution shape with wrong mark parity
    } sym_kind_e;

    // One result travelling through the alignment line
    typedef struct packed {
        logic data;
        logic flag;
    } slot_t;

    function automatic logic is_same_pol(sym_kind_e k);
        return (k == SYM_SUBST) || (k == SYM_BPV) || (k == SYM_CODEV);
    endfunction

endpackage

// File: rtl/rzd_classify.sv
module rzd_classify
    import rzd_pkg::*;
#(
    parameter int B3_RUN = 3,
    parameter int HD_RUN = 4,
    parameter int ZW     = 3
) (
    input  logic          rail_p,
    input  logic          rail_n,
    input  logic          hdb3_sel,
    input  logic          seen,
    input  logic          last_neg,
    input  logic          par_odd,
    input  logic [ZW-1:0] zrun,
    output sym_kind_e     kind,
    output logic          mark_neg
);

    logic [ZW-1:0] run_len;
    logic [ZW-1:0] pre_len;

    always_comb begin
        run_len  = hdb3_sel ? ZW'(HD_RUN) : ZW'(B3_RUN);
        pre_len  = run_len - ZW'(2);
        mark_neg = rail_n & ~rail_p;
        if (rail_p == rail_n) begin
            // a space; the Nth one in a row is excessive
            kind = (zrun == run_len - ZW'(1)) ? SYM_EXZ : SYM_SPACE;
        end else if (!seen || (mark_neg != last_neg)) begin
            kind = SYM_MARK;
        end else if (zrun >= pre_len) begin
            kind = par_odd ? SYM_SUBST : SYM_CODEV;
        end else begin
            kind = SYM_BPV;
        end
    end

endmodule

// File: rtl/rzd_track.sv
module rzd_track
    import rzd_pkg::*;
#(
    parameter int B3_RUN = 3,
    parameter int HD_RUN = 4,
    parameter int ZW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          nrz_sel,
    input  sym_kind_e     kind,
    input  logic          mark_neg,
    output logic          seen,
    output logic          last_neg,
    output logic          par_odd,
    output logic [ZW-1:0] zrun
);

    localparam logic [ZW-1:0] RUN_CAP = ZW'((HD_RUN > B3_RUN) ? HD_RUN : B3_RUN);

    typedef struct packed {
        logic          seen;
        logic          last_neg;
        logic          par_odd;
        logic [ZW-1:0] zrun;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!nrz_sel) begin
            st_d = '0;
        end else if (bit_en) begin
            unique case (kind)
                SYM_SPACE, SYM_EXZ: begin
                    if (st_q.zrun < RUN_CAP) st_d.zrun = st_q.zrun + ZW'(1);
                end
                SYM_MARK: begin
                    st_d.seen     = 1'b1;
                    st_d.last_neg = mark_neg;
                    st_d.par_odd  = ~st_q.par_odd;
                    st_d.zrun     = '0;
                end
                default: begin
                    st_d.seen     = 1'b1;
                    st_d.last_neg = mark_neg;
                    st_d.par_odd  = 1'b0;
                    st_d.zrun     = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seen     = st_q.seen;
    assign last_neg = st_q.last_neg;
    assign par_odd  = st_q.par_odd;
    assign zrun     = st_q.zrun;

    // R9: any same-polarity mark leaves the parity even
    a_r9_parity_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (nrz_sel && bit_en && is_same_pol(kind)) |=> !par_odd);

    // R8: the zero-run count never passes the longest run length
    a_r8_run_capped: assert property (@(posedge clk) disable iff (!rst_n)
        zrun <= RUN_CAP);

    // R2: no strobe, no change of decoder state
    a_r2_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (nrz_sel && !bit_en) |=> $stable(st_q));

endmodule

// File: rtl/rzd_align.sv
module rzd_align
    import rzd_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_en,
    input  slot_t          in_slot,
    input  logic [LAT-1:0] clr_mask,
    output slot_t          out_slot
);

    typedef struct packed {
        slot_t [LAT-1:0] pipe;
        slot_t           hold;
    } aln_t;

    aln_t aln_d, aln_q;

    always_comb begin
        aln_d = aln_q;
        if (bit_en) begin
            aln_d.pipe[0] = in_slot;
            for (int i = 1; i < LAT; i++) begin
                aln_d.pipe[i]      = aln_q.pipe[i-1];
                aln_d.pipe[i].data = aln_q.pipe[i-1].data & ~clr_mask[i-1];
            end
            aln_d.hold      = aln_q.pipe[LAT-1];
            aln_d.hold.data = aln_q.pipe[LAT-1].data & ~clr_mask[LAT-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) aln_q <= '0;
        else        aln_q <= aln_d;
    end

    assign out_slot = aln_q.hold;

    // R4: a legal substitution empties the result just behind it
    a_r4_clear_applied: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && clr_mask[0]) |=> !aln_q.pipe[1].data);

    // R2: outputs hold between strobes
    a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(out_slot));

endmodule

// File: rtl/rzd_decoder.sv
module rzd_decoder
    import rzd_pkg::*;
#(
    parameter int LATENCY  = 4,
    parameter int B3ZS_RUN = 3,
    parameter int HDB3_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rail_p,
    input  logic rail_n,
    input  logic hdb3_sel,
    input  logic nrz_sel,
    output logic nrz_data,
    output logic viol_flag
);

    localparam int MAX_RUN = (HDB3_RUN > B3ZS_RUN) ? HDB3_RUN : B3ZS_RUN;
    localparam int ZW      = $clog2(MAX_RUN + 1);

    sym_kind_e        kind;
    logic             mark_neg;
    logic             seen;
    logic             last_neg;
    logic             par_odd;
    logic [ZW-1:0]    zrun;
    logic [ZW-1:0]    clr_span;
    logic [LATENCY-1:0] clr_mask;
    slot_t            in_slot;
    slot_t            out_slot;

    rzd_classify #(.B3_RUN(B3ZS_RUN), .HD_RUN(HDB3_RUN), .ZW(ZW)) u_classify (
        .rail_p   (rail_p),
        .rail_n   (rail_n),
        .hdb3_sel (hdb3_sel),
        .seen     (seen),
        .last_neg (last_neg),
        .par_odd  (par_odd),
        .zrun     (zrun),
        .kind     (kind),
        .mark_neg (mark_neg)
    );

    rzd_track #(.B3_RUN(B3ZS_RUN), .HD_RUN(HDB3_RUN), .ZW(ZW)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .nrz_sel  (nrz_sel),
        .kind     (kind),
        .mark_neg (mark_neg),
        .seen     (seen),
        .last_neg (last_neg),
        .par_odd  (par_odd),
        .zrun     (zrun)
    );

    // results behind a legal substitution that must be cleared
    assign clr_span = hdb3_sel ? ZW'(HDB3_RUN - 1) : ZW'(B3ZS_RUN - 1);

    for (genvar g = 0; g < LATENCY; g++) begin : g_clr
        assign clr_mask[g] = nrz_sel && (kind == SYM_SUBST) && (g < int'(clr_span));
    end

    always_comb begin
        if (nrz_sel) begin
            in_slot.data = kind inside {SYM_MARK, SYM_BPV, SYM_CODEV};
            in_slot.flag = kind inside {SYM_EXZ, SYM_BPV, SYM_CODEV};
        end else begin
            in_slot.data = rail_p;
            in_slot.flag = rail_n;
        end
    end

    rzd_align #(.LAT(LATENCY)) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .in_slot  (in_slot),
        .clr_mask (clr_mask),
        .out_slot (out_slot)
    );

    assign nrz_data  = out_slot.data;
    assign viol_flag = out_slot.flag;

    // R10: reset holds both outputs low
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!nrz_data && !viol_flag));

endmodule

// File: tb/sim_rzd_decoder.sv
module sim_rzd_decoder;

    localparam int MAXN = 640;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n    = 1'b0;
    logic bit_en   = 1'b0;
    logic rail_p   = 1'b0;
    logic rail_n   = 1'b0;
    logic hdb3_sel = 1'b0;
    logic nrz_sel  = 1'b0;
    logic nrz_data;
    logic viol_flag;

    int n_tests = 0;
    int n_fail  = 0;

    // symbol codes: 0 space, 1 positive mark, 2 negative mark, 3 both rails
    int   sym [MAXN];
    logic ed  [MAXN];
    logic ef  [MAXN];
    int   len;

    rzd_decoder u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .rail_p    (rail_p),
        .rail_n    (rail_n),
        .hdb3_sel  (hdb3_sel),
        .nrz_sel   (nrz_sel),
        .nrz_data  (nrz_data),
        .viol_flag (viol_flag)
    );

    task automatic chk(input string tag, input logic ad, input logic af,
                       input logic xd, input logic xf);
        n_tests++;
        if (ad !== xd || af !== xf) begin
            n_fail++;
            $display("FAIL %s: data/flag got %b/%b expected %b/%b", tag, ad, af, xd, xf);
        end
    endtask

    task automatic drive_sym(input int s);
        rail_p = (s == 1) || (s == 3);
        rail_n = (s == 2) || (s == 3);
    endtask

    // reset, then push len symbols plus four pads, checking every result
    task automatic run_stream(input logic hdb, input logic nrz, input string tag);
        logic pd, pf;
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; hdb3_sel = hdb; nrz_sel = nrz;
        repeat (2) @(negedge clk);
        chk("R10 outputs low in reset", nrz_data, viol_flag, 1'b0, 1'b0);
        rst_n = 1'b1;
        pd = 1'b0; pf = 1'b0;
        for (int k = 0; k < len + 4; k++) begin
            int gaps;
            int idx;
            gaps = $urandom_range(0, 2);
            for (int g = 0; g < gaps; g++) begin
                bit_en = 1'b0;
                drive_sym($urandom_range(0, 3));
                @(negedge clk);
                chk("R2 hold without strobe", nrz_data, viol_flag, pd, pf);
            end
            drive_sym((k < len) ? sym[k] : 3);
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
            idx = k - 4;
            if (idx < 0) begin
                pd = 1'b0; pf = 1'b0;
                chk("R10 cleared after reset", nrz_data, viol_flag, pd, pf);
            end else if (idx < len) begin
                pd = ed[idx]; pf = ef[idx];
                chk(tag, nrz_data, viol_flag, pd, pf);
            end else begin
                pd = nrz_data; pf = viol_flag;
            end
        end
    endtask

    task automatic directed(input logic hdb, input string pat, input string dx,
                            input string fx, input string tag);
        len = pat.len();
        for (int i = 0; i < len; i++) begin
            sym[i] = (pat[i] == "+") ? 1 : (pat[i] == "-") ? 2 : (pat[i] == "x") ? 3 : 0;
            ed[i]  = (dx[i] == "1");
            ef[i]  = (fx[i] == "1");
        end
        run_stream(hdb, 1'b1, tag);
    endtask

    // sequential reference of the decoding rules
    task automatic ref_model(input logic hdb);
        int   n;
        int   zr;
        logic seen, lneg, par;
        n = hdb ? 4 : 3;
        zr = 0; seen = 1'b0; lneg = 1'b0; par = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (sym[i] == 0 || sym[i] == 3) begin
                zr++;
                ed[i] = 1'b0;
                ef[i] = (zr == n);
            end else begin
                logic neg;
                neg = (sym[i] == 2);
                if (!seen || neg != lneg) begin
                    ed[i] = 1'b1; ef[i] = 1'b0; par = ~par;
                end else begin
                    if (zr >= n - 2 && par) begin
                        ed[i] = 1'b0; ef[i] = 1'b0;
                        for (int j = 1; j < n; j++) ed[i-j] = 1'b0;
                    end else begin
                        ed[i] = 1'b1; ef[i] = 1'b1;
                    end
                    par = 1'b0;
                end
                seen = 1'b1; lneg = neg; zr = 0;
            end
        end
    endtask

    // line encoder: expected output is the source bits with no flag
    task automatic encode(input logic hdb);
        int   n;
        int   zc;
        logic lneg, par;
        n = hdb ? 4 : 3;
        zc = 0; lneg = 1'b1; par = 1'b0;
        for (int i = 0; i < len; i++) begin
            logic b;
            b = ($urandom_range(0, 9) < 4);
            ed[i] = b; ef[i] = 1'b0;
            if (b) begin
                lneg = ~lneg; sym[i] = lneg ? 2 : 1; par = ~par; zc = 0;
            end else begin
                sym[i] = 0; zc++;
                if (zc == n) begin
                    if (!par) begin
                        lneg = ~lneg;
                        sym[i-n+1] = lneg ? 2 : 1;
                    end
                    sym[i] = lneg ? 2 : 1;
                    par = 1'b0; zc = 0;
                end
            end
        end
    endtask

    task automatic random_syms();
        for (int i = 0; i < len; i++) begin
            int r;
            r = $urandom_range(0, 9);
            sym[i] = (r < 5) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog: got still running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));

        // R1: rail pass-through, both codes selected
        for (int m = 0; m < 2; m++) begin
            len = 200;
            random_syms();
            for (int i = 0; i < len; i++) begin
                ed[i] = (sym[i] == 1) || (sym[i] == 3);
                ef[i] = (sym[i] == 2) || (sym[i] == 3);
            end
            run_stream(m[0], 1'b0, "R1 rail pass-through");
        end

        // directed corner cases, hand-computed results
        directed(1'b0, "++",      "11",      "01",      "R5 adjacent pair B3ZS");
        directed(1'b1, "--",      "11",      "01",      "R5 adjacent pair HDB3");
        directed(1'b1, "-0-",     "101",     "001",     "R6 split pair HDB3");
        directed(1'b0, "+00+",    "1000",    "0000",    "R4 B3ZS zeros-then-V");
        directed(1'b0, "+-+0+",   "11000",   "00000",   "R4 B3ZS B-zero-V");
        directed(1'b1, "+000+",   "10000",   "00000",   "R4 HDB3 zeros-then-V");
        directed(1'b1, "-+-00-",  "110000",  "000000",  "R4 HDB3 B-zeros-V");
        directed(1'b0, "+-0-",    "1101",    "0001",    "R7 B3ZS even parity");
        directed(1'b1, "+-00-",   "11001",   "00001",   "R7 HDB3 even parity");
        directed(1'b1, "+0000-",  "100001",  "000010",  "R8 HDB3 four zeros");
        directed(1'b0, "-00000+", "1000001", "0001000", "R8 B3ZS run flagged once");
        directed(1'b0, "+x-",     "101",     "000",     "R3 both rails read as space");
        directed(1'b0, "+00+0+",  "100001",  "000001",  "R9 parity cleared by V");
        directed(1'b1, "00+",     "001",     "000",     "R9 R3 first mark after reset");

        // encoded streams must decode to their source bits
        for (int m = 0; m < 2; m++) begin
            len = 500;
            encode(m[0]);
            run_stream(m[0], 1'b1, "R4 R2 encoded stream");
        end

        // random ternary streams against the reference rules
        for (int m = 0; m < 2; m++) begin
            len = 500;
            random_syms();
            ref_model(m[0]);
            run_stream(m[0], 1'b1, "model R3 R5 R6 R7 R8 R9");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule